// File: doc/BRIEF.md
# External Memory Bus Wait-State Controller

This block runs read and write cycles on an external asynchronous memory bus on behalf of a processor core. The core raises a request together with a direction flag, an address, write data and a flag marking the access as a DRAM-type access. The controller then drives active-low read or write enables, the address, two chip-select style attribute lines and, for writes, the data bus. When the cycle ends it returns read data and pulses a ready strobe to the core.

A cycle always lasts at least the programmed number of wait states plus one clock. When the wait count is nonzero and the access is not DRAM-type, the memory can stretch the cycle for as long as it likes by holding its acknowledge input low. The cycle then ends one clock after the acknowledge is sampled high. A mode input chooses between sampling the acknowledge directly and passing it through a two-flop synchronizer first. All bus control outputs and the data bus float while reset is asserted and while the device is in a low-power mode.

Top module: `ext_bus_waitctl`

## Requirements
- R1: `bus_rd_n_o` is 0 only while a read access is in progress, and `bus_wr_n_o` is 0 only while a write access is in progress. Both are 1 between accesses, and they are never 0 together.
- R2: While `rst_n` is 0 or `lowpwr_i` is 1, `ctl_oe_o` and `bus_d_oe_o` are 0, which floats the strobes, the attribute lines and the data bus.
- R3: Attribute line k is assigned the region value in bits [2k+1:2k] of `cfg_attr_sel_i`. During an access whose address bits [15:14] equal that value, the line drives `cfg_attr_pol_i[k]`. At every other time it drives the inverse of `cfg_attr_pol_i[k]`.
- R4: With `cfg_wait_i` = 0 at acceptance, the strobe is held for exactly 1 clock and `bus_ack_i` has no effect.
- R5: With `cfg_wait_i` = W > 0, a non-DRAM access and `cfg_ack_async_i` = 0, the acknowledge is first high in strobe clock k (counting from 0). The strobe is then held for max(W+1, k+2) clocks.
- R6: Under the same conditions with `cfg_ack_async_i` = 1, the strobe is held for max(W+1, k+3) clocks.
- R7: When `dram_i` = 1 at acceptance, the strobe is held for exactly W+1 clocks whatever `bus_ack_i` does.
- R8: `bus_ack_i` is ignored while no access is in progress. An acknowledge that is high only before an access starts does not shorten that access.
- R9: `ready_o` is 1 for exactly the single clock that follows the last strobe clock. On a read, `rdata_o` then holds the value `bus_d_i` had in the last strobe clock.
- R10: During a write access `bus_d_oe_o` is 1 for every strobe clock and `bus_d_o` equals the write data. During reads and between accesses `bus_d_oe_o` is 0.
- R11: A request is not accepted while `lowpwr_i` is 1 or while an access is in progress. No strobe follows such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| lowpwr_i | input | 1 | Stop/wait low-power mode; floats the bus |
| cfg_wait_i | input | 4 | Minimum wait-state count |
| cfg_ack_async_i | input | 1 | 1: acknowledge goes through the synchronizer |
| cfg_attr_pol_i | input | 2 | Active level of each attribute line |
| cfg_attr_sel_i | input | 4 | Region value per attribute line, 2 bits each |
| req_i | input | 1 | Access request from the core |
| we_i | input | 1 | 1 = write, 0 = read |
| dram_i | input | 1 | Access is DRAM type; acknowledge is not used |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-clock completion strobe |
| rdata_o | output | 8 | Captured read data |
| bus_addr_o | output | 16 | External address |
| bus_rd_n_o | output | 1 | Read enable, active low |
| bus_wr_n_o | output | 1 | Write enable, active low |
| ctl_oe_o | output | 1 | Output enable for strobes and attribute lines |
| bus_d_o | output | 8 | Data bus, outgoing value |
| bus_d_i | input | 8 | Data bus, incoming value |
| bus_d_oe_o | output | 1 | Data bus output enable |
| bus_attr_o | output | 2 | Address-attribute / chip-select lines |
| bus_ack_i | input | 1 | Transfer acknowledge, active high |

## Verification
The minimum wait count and the acknowledge path can both end a cycle in the same clock. This happens when the acknowledge delay k equals W-1 in synchronous mode or W-2 in asynchronous mode. A sweep over W from 0 to 4, k from 0 to 5, both sampling modes, both DRAM settings and both directions lands on that crossing, and on either side of it, for every configuration. Each run measures the strobe length at the ports and compares it with the maximum formula, or with W+1 where the acknowledge must be ignored.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } ebw_state_e;

endpackage

// File: rtl/ebw_ack_sync.sv
// Acknowledge sampling path: one flop in synchronous mode, the full chain in
// asynchronous mode. The chain is held clear while no access is running.
module ebw_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic async_mode,
    input  logic ack_in,
    output logic ack_seen
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = '0;
        if (active) begin
            chain_d[0] = ack_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_d[i] = chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign ack_seen = async_mode ? chain_q[LAST] : chain_q[0];

endmodule

// File: rtl/ebw_attr_decode.sv
// Region match for the address-attribute lines with per-line polarity.
module ebw_attr_decode #(
    parameter int NATTR = 2,
    parameter int RW    = 2
) (
    input  logic [RW-1:0]       addr_top,
    input  logic                active,
    input  logic [NATTR*RW-1:0] sel,
    input  logic [NATTR-1:0]    pol,
    output logic [NATTR-1:0]    attr
);

    for (genvar k = 0; k < NATTR; k++) begin : g_attr
        logic hit;
        assign hit     = active && (addr_top == sel[k*RW +: RW]);
        assign attr[k] = hit ? pol[k] : ~pol[k];
    end

endmodule

// File: rtl/ebw_seq.sv
// Access sequencer: latches a request, counts wait states, waits for the
// acknowledge where it applies, captures read data and pulses ready.
module ebw_seq
    import ebw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_en,
    input  logic [WW-1:0] cfg_wait,
    input  logic          req,
    input  logic          we,
    input  logic          dram,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] din,
    input  logic          ack_seen,
    output logic          active,
    output logic          we_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          ready_q
);

    typedef struct packed {
        ebw_state_e    st;
        logic [WW-1:0] cnt;
        logic          nowait;
        logic          we;
        logic          dram;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ready;
    } seq_t;

    seq_t s_d;
    seq_t s_q;
    logic cnt_done;
    logic may_end;

    assign cnt_done = (s_q.cnt == '0);
    assign may_end  = s_q.nowait || s_q.dram || ack_seen;

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req && accept_en) begin
                    s_d.st     = ST_ACCESS;
                    s_d.cnt    = cfg_wait;
                    s_d.nowait = (cfg_wait == '0);
                    s_d.we     = we;
                    s_d.dram   = dram;
                    s_d.addr   = addr;
                    s_d.wdata  = wdata;
                end
            end
            ST_ACCESS: begin
                if (!cnt_done) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (may_end) begin
                    s_d.st    = ST_IDLE;
                    s_d.ready = 1'b1;
                    if (!s_q.we) begin
                        s_d.rdata = din;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active  = (s_q.st == ST_ACCESS);
    assign we_q    = s_q.we;
    assign addr_q  = s_q.addr;
    assign wdata_q = s_q.wdata;
    assign rdata_q = s_q.rdata;
    assign ready_q = s_q.ready;

endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int WW         = 4,
    parameter int NATTR      = 2,
    parameter int RW         = 2,
    parameter int ACK_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lowpwr_i,
    input  logic [WW-1:0]       cfg_wait_i,
    input  logic                cfg_ack_async_i,
    input  logic [NATTR-1:0]    cfg_attr_pol_i,
    input  logic [NATTR*RW-1:0] cfg_attr_sel_i,
    input  logic                req_i,
    input  logic                we_i,
    input  logic                dram_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    output logic                ready_o,
    output logic [DW-1:0]       rdata_o,
    output logic [AW-1:0]       bus_addr_o,
    output logic                bus_rd_n_o,
    output logic                bus_wr_n_o,
    output logic                ctl_oe_o,
    output logic [DW-1:0]       bus_d_o,
    input  logic [DW-1:0]       bus_d_i,
    output logic                bus_d_oe_o,
    output logic [NATTR-1:0]    bus_attr_o,
    input  logic                bus_ack_i
);

    logic          active;
    logic          we_q;
    logic          ack_seen;
    logic [AW-1:0] addr_q;

    ebw_ack_sync #(
        .STAGES(ACK_STAGES)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .async_mode(cfg_ack_async_i),
        .ack_in    (bus_ack_i),
        .ack_seen  (ack_seen)
    );

    ebw_seq #(
        .AW(AW),
        .DW(DW),
        .WW(WW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_en(!lowpwr_i),
        .cfg_wait (cfg_wait_i),
        .req      (req_i),
        .we       (we_i),
        .dram     (dram_i),
        .addr     (addr_i),
        .wdata    (wdata_i),
        .din      (bus_d_i),
        .ack_seen (ack_seen),
        .active   (active),
        .we_q     (we_q),
        .addr_q   (addr_q),
        .wdata_q  (bus_d_o),
        .rdata_q  (rdata_o),
        .ready_q  (ready_o)
    );

    ebw_attr_decode #(
        .NATTR(NATTR),
        .RW   (RW)
    ) u_attr (
        .addr_top(addr_q[AW-1 -: RW]),
        .active  (active),
        .sel     (cfg_attr_sel_i),
        .pol     (cfg_attr_pol_i),
        .attr    (bus_attr_o)
    );

    assign bus_addr_o = addr_q;
    assign bus_rd_n_o = !(active && !we_q);
    assign bus_wr_n_o = !(active && we_q);
    assign ctl_oe_o   = rst_n && !lowpwr_i;
    assign bus_d_oe_o = ctl_oe_o && active && we_q;

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int WW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lowpwr_i,
    input logic [WW-1:0] cfg_wait_i,
    input logic          ready_o,
    input logic          bus_rd_n_o,
    input logic          bus_wr_n_o,
    input logic          ctl_oe_o,
    input logic          bus_d_oe_o
);

    logic strobe_on;
    assign strobe_on = !bus_rd_n_o || !bus_wr_n_o;

    // R1: never both strobes at once
    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n_o && !bus_wr_n_o));

    // R2: floating during reset
    always_comb begin
        if (!rst_n) begin
            assert_float_reset_R2: assert (!ctl_oe_o && !bus_d_oe_o);
        end
    end

    // R2: floating in low-power mode
    assert_float_lowpwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_i |-> (!ctl_oe_o && !bus_d_oe_o));

    // R4: zero-wait access keeps the strobe one clock
    assert_zero_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && !$past(strobe_on) && cfg_wait_i == '0 && $stable(cfg_wait_i))
        |=> !strobe_on);

    // R9: ready is a single-clock pulse that follows a strobe clock
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    assert_ready_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(strobe_on));

    // R10: data drive only with the write strobe
    assert_doe_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe_o |-> (!bus_wr_n_o && bus_rd_n_o));

endmodule

bind ext_bus_waitctl ebw_checker #(
    .WW(WW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lowpwr_i  (lowpwr_i),
    .cfg_wait_i(cfg_wait_i),
    .ready_o   (ready_o),
    .bus_rd_n_o(bus_rd_n_o),
    .bus_wr_n_o(bus_wr_n_o),
    .ctl_oe_o  (ctl_oe_o),
    .bus_d_oe_o(bus_d_oe_o)
);

// File: tb/ext_bus_waitctl_test.sv
module ext_bus_waitctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lowpwr_i = 1'b0;
    logic [3:0]  cfg_wait_i = '0;
    logic        cfg_ack_async_i = 1'b0;
    logic [1:0]  cfg_attr_pol_i = 2'b01;
    logic [3:0]  cfg_attr_sel_i = {2'd2, 2'd1};
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic        dram_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        ready_o;
    logic [7:0]  rdata_o;
    logic [15:0] bus_addr_o;
    logic        bus_rd_n_o;
    logic        bus_wr_n_o;
    logic        ctl_oe_o;
    logic [7:0]  bus_d_o;
    logic [7:0]  bus_d_i = '0;
    logic        bus_d_oe_o;
    logic [1:0]  bus_attr_o;
    logic        bus_ack_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 20 ns period, 50 MHz

    ext_bus_waitctl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lowpwr_i       (lowpwr_i),
        .cfg_wait_i     (cfg_wait_i),
        .cfg_ack_async_i(cfg_ack_async_i),
        .cfg_attr_pol_i (cfg_attr_pol_i),
        .cfg_attr_sel_i (cfg_attr_sel_i),
        .req_i          (req_i),
        .we_i           (we_i),
        .dram_i         (dram_i),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .ready_o        (ready_o),
        .rdata_o        (rdata_o),
        .bus_addr_o     (bus_addr_o),
        .bus_rd_n_o     (bus_rd_n_o),
        .bus_wr_n_o     (bus_wr_n_o),
        .ctl_oe_o       (ctl_oe_o),
        .bus_d_o        (bus_d_o),
        .bus_d_i        (bus_d_i),
        .bus_d_oe_o     (bus_d_oe_o),
        .bus_attr_o     (bus_attr_o),
        .bus_ack_i      (bus_ack_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] attr_exp(input bit act, input logic [1:0] top);
        logic [1:0] r;
        for (int k = 0; k < 2; k++) begin
            r[k] = (act && top == cfg_attr_sel_i[k*2 +: 2]) ? cfg_attr_pol_i[k]
                                                           : ~cfg_attr_pol_i[k];
        end
        return r;
    endfunction

    task automatic run_access(input int w, input int k, input bit asy, input bit drm,
                              input bit wr, input bit preack, input int top);
        int idx = 0;
        int exp_len;
        bit attr_ok = 1'b1;
        bit dat_ok = 1'b1;
        bit strb_ok = 1'b1;
        logic [7:0] last_d = '0;
        logic [7:0] wd;
        wd = 8'(8'h5A ^ (w * 16 + k));
        if (preack) begin
            @(negedge clk);
            bus_ack_i = 1'b1;
            @(negedge clk);
        end else begin
            @(negedge clk);
        end
        cfg_wait_i      = 4'(w);
        cfg_ack_async_i = asy;
        dram_i          = drm;
        we_i            = wr;
        addr_i          = {2'(top), 14'(w * 37 + k)};
        wdata_i         = wd;
        req_i           = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wdata_i = '0;
        while ((!bus_rd_n_o || !bus_wr_n_o) && idx < 40) begin
            bus_ack_i = (idx >= k);
            bus_d_i   = 8'(8'hC0 + idx);
            last_d    = bus_d_i;
            if (bus_attr_o != attr_exp(1'b1, 2'(top))) attr_ok = 1'b0;
            if (wr) begin
                if (!bus_d_oe_o || bus_d_o != wd || bus_wr_n_o == 1'b1) dat_ok = 1'b0;
                if (!bus_rd_n_o) strb_ok = 1'b0;
            end else begin
                if (bus_d_oe_o) dat_ok = 1'b0;
                if (!bus_wr_n_o) strb_ok = 1'b0;
            end
            @(negedge clk);
            idx++;
        end
        if (w == 0 || drm) exp_len = w + 1;
        else exp_len = (w + 1 > k + 2 + asy) ? w + 1 : k + 2 + asy;
        if (w == 0)      check(idx == exp_len, "R4", "zero-wait length", idx, exp_len);
        else if (drm)    check(idx == exp_len, "R7", "dram length", idx, exp_len);
        else if (preack) check(idx == exp_len, "R8", "length after idle ack", idx, exp_len);
        else if (asy)    check(idx == exp_len, "R6", "async length", idx, exp_len);
        else             check(idx == exp_len, "R5", "sync length", idx, exp_len);
        check(ready_o == 1'b1, "R9", "ready after last strobe", int'(ready_o), 1);
        if (!wr) check(rdata_o == last_d, "R9", "read data", int'(rdata_o), int'(last_d));
        check(attr_ok, "R3", "attribute levels during access", int'(attr_ok), 1);
        check(dat_ok, "R10", "data drive during access", int'(dat_ok), 1);
        check(strb_ok, "R1", "strobe direction", int'(strb_ok), 1);
        check(bus_attr_o == attr_exp(1'b0, 2'(top)), "R3", "attribute idle level",
              int'(bus_attr_o), int'(attr_exp(1'b0, 2'(top))));
        bus_ack_i = 1'b0;
        @(negedge clk);
        check(ready_o == 1'b0, "R9", "ready one clock", int'(ready_o), 0);
        check(bus_rd_n_o && bus_wr_n_o && !bus_d_oe_o, "R1", "idle strobes",
              int'({bus_rd_n_o, bus_wr_n_o, bus_d_oe_o}), 6);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ctl_oe_o && !bus_d_oe_o, "R2", "float in reset",
              int'({ctl_oe_o, bus_d_oe_o}), 0);
        check(ready_o == 1'b0, "R9", "ready in reset", int'(ready_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_oe_o && bus_rd_n_o && bus_wr_n_o, "R1", "driven idle after reset",
              int'({ctl_oe_o, bus_rd_n_o, bus_wr_n_o}), 7);

        // low-power: floats and refuses requests (R2, R11)
        lowpwr_i = 1'b1;
        req_i = 1'b1;
        we_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        check(!ctl_oe_o && !bus_d_oe_o, "R2", "float in low power",
              int'({ctl_oe_o, bus_d_oe_o}), 0);
        repeat (3) @(negedge clk);
        check(bus_rd_n_o && bus_wr_n_o && !ready_o, "R11", "no access in low power",
              int'({bus_rd_n_o, bus_wr_n_o, ready_o}), 6);
        lowpwr_i = 1'b0;
        @(negedge clk);
        check(ctl_oe_o == 1'b1, "R2", "driven after low power", int'(ctl_oe_o), 1);

        // main sweep, including the wait/ack crossing points
        for (int w = 0; w <= 4; w++) begin
            for (int k = 0; k <= 5; k++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int d = 0; d < 2; d++) begin
                        cfg_attr_pol_i = 2'(a + 2 * d);
                        run_access(w, k, 1'(a), 1'(d), 1'((w + k + d) % 2),
                                   k >= 3, (w + k + a) % 4);
                    end
                end
            end
        end

        // request during a busy access is dropped (R11)
        begin
            int len = 0;
            @(negedge clk);
            cfg_wait_i = 4'd3;
            dram_i = 1'b1;
            we_i = 1'b0;
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            @(negedge clk);
            len = 1;
            we_i = 1'b1;
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            len++;
            while (!bus_rd_n_o && len < 40) begin
                @(negedge clk);
                len++;
            end
            check(len == 4, "R7", "busy dram length", len, 4);
            check(ready_o == 1'b1, "R9", "ready after busy access", int'(ready_o), 1);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(bus_rd_n_o && bus_wr_n_o, "R11", "request while busy ignored",
                      int'({bus_rd_n_o, bus_wr_n_o}), 3);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule